// File: doc/BRIEF.md
# Alternate-Function Select Write Guard

This block holds the alternate-function select bits of a general-purpose I/O port and protects them so that software cannot change them by accident. A commit mask chooses which select bits respond to writes. The mask can be rewritten only while the unit is open. Software opens the unit by writing a fixed 32-bit key to the lock register. Writing any other value to the lock register closes the unit again.

A typical driver writes the key and then programs the commit mask. It updates the alternate-function bits and closes the unit by writing any non-key value. The stored select bits go out on an output port that drives the pin multiplexers elsewhere in the chip. The register interface is a simple single-cycle write strobe with an address and data. Read data is combinational from the address.

Top module: `afg_guard`

## Requirements
- R1: After reset the lock register reads 1, the commit register reads 0xFF, and the select register and the `af_sel_o` port both read 0.
- R2: Writing exactly 0x0ACCE551 to the lock register (offset 0x520) opens the unit. The lock register then reads 0.
- R3: Writing any 32-bit value other than 0x0ACCE551 to the lock register closes the unit. The lock register then reads 1.
- R4: A write to the commit register (offset 0x524) while the unit is closed leaves the commit register unchanged.
- R5: A write to the commit register while the unit is open stores bits [7:0] of the write data. The upper data bits are discarded, and the register reads back zero-extended.
- R6: The unit stays open across any number of commit and select writes. It closes only when a non-key value is written to the lock register.
- R7: A write to the select register (offset 0x420) updates only the bits whose commit bit is 1. Each new value is new = (old & ~commit) | (wdata & commit).
- R8: The `af_sel_o` port always equals the value read from the select register.
- R9: Reads from any offset other than 0x420, 0x520 and 0x524 return 0. Writes to such offsets change none of the three registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | 12 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| af_sel_o | output | 8 | Stored alternate-function select bits |

## Verification
The assertions check four things on every cycle. The key write opens the unit and any other lock write closes it. The lock state holds when nothing is written to it. The commit register stays frozen while the unit is closed. No select bit outside the commit mask ever changes. The bench scenarios show everything that depends on the value chosen: the exact key against each single-bit-flipped near miss, and truncation of wide commit data. They also show the read-back of all 256 commit masks combined with many select data patterns, and that writes to unmapped offsets and reads from them have no effect.

// File: rtl/afg_pkg.sv
package afg_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned AF_W   = 8;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h0ACC_E551;

  localparam logic [ADDR_W-1:0] OFS_ALTFN  = 12'h420;
  localparam logic [ADDR_W-1:0] OFS_LOCK   = 12'h520;
  localparam logic [ADDR_W-1:0] OFS_COMMIT = 12'h524;

  typedef struct packed {
    logic lock;
    logic commit;
    logic altfn;
  } wr_sel_t;
endpackage

// File: rtl/afg_lock.sv
module afg_lock #(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY = 32'h0ACC_E551
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lock,
  input  logic [DATA_W-1:0] wdata,
  output logic              locked
);
  logic lock_q, lock_d, lock_ce;

  always_comb begin
    lock_ce = wr_lock;
    lock_d  = (wdata != KEY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lock_q <= 1'b1;
    else if (lock_ce) lock_q <= lock_d;
  end

  assign locked = lock_q;

  AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lock && wdata == KEY) |=> !locked); // R2
  AST_OTHER_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lock && wdata != KEY) |=> locked); // R3
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lock |=> $stable(locked)); // R6
endmodule

// File: rtl/afg_commit.sv
module afg_commit #(
  parameter int unsigned AF_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_commit,
  input  logic            locked,
  input  logic [AF_W-1:0] wdata,
  output logic [AF_W-1:0] commit
);
  logic [AF_W-1:0] cm_q, cm_d;
  logic            cm_ce;

  always_comb begin
    cm_ce = wr_commit & ~locked;
    cm_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cm_q <= '1;
    else if (cm_ce) cm_q <= cm_d;
  end

  assign commit = cm_q;

  AST_COMMIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(commit)); // R4
  AST_COMMIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> $stable(commit)); // R9
endmodule

// File: rtl/afg_altfn.sv
module afg_altfn #(
  parameter int unsigned AF_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_af,
  input  logic [AF_W-1:0] mask,
  input  logic [AF_W-1:0] wdata,
  output logic [AF_W-1:0] af
);
  logic [AF_W-1:0] af_q, af_d;
  logic            af_ce;

  always_comb begin
    af_ce = wr_af;
    af_d  = af_q;
    for (int i = 0; i < int'(AF_W); i++) begin
      if (mask[i]) af_d[i] = wdata[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     af_q <= '0;
    else if (af_ce) af_q <= af_d;
  end

  assign af = af_q;

  AST_UNMASKED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_af |=> (((af ^ $past(af)) & ~$past(mask)) == '0)); // R7
  AST_AF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_af |=> $stable(af)); // R9
endmodule

// File: rtl/afg_rdmux.sv
module afg_rdmux
  import afg_pkg::*;
#(
  parameter int unsigned AW   = 12,
  parameter int unsigned DW   = 32,
  parameter int unsigned AFW  = 8
) (
  input  logic [AW-1:0]  addr,
  input  logic           locked,
  input  logic [AFW-1:0] commit,
  input  logic [AFW-1:0] af,
  output logic [DW-1:0]  rdata
);
  always_comb begin
    rdata = '0;
    unique case (addr)
      OFS_LOCK:   rdata[0]       = locked;
      OFS_COMMIT: rdata[AFW-1:0] = commit;
      OFS_ALTFN:  rdata[AFW-1:0] = af;
      default:    rdata          = '0;
    endcase
  end
endmodule

// File: rtl/afg_guard.sv
module afg_guard
  import afg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [AF_W-1:0]   af_sel_o
);
  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  wr_sel_t         wsel;
  logic            locked;
  logic [AF_W-1:0] commit;
  logic [AF_W-1:0] af;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    wsel.lock   = bus_wr && (bus_addr == OFS_LOCK);
    wsel.commit = bus_wr && (bus_addr == OFS_COMMIT);
    wsel.altfn  = bus_wr && (bus_addr == OFS_ALTFN);
  end

  afg_lock #(.DATA_W(DATA_W), .KEY(UNLOCK_KEY)) u_lock (
    .clk(clk), .rst_n(rst_int_n), .wr_lock(wsel.lock),
    .wdata(bus_wdata), .locked(locked));

  afg_commit #(.AF_W(AF_W)) u_commit (
    .clk(clk), .rst_n(rst_int_n), .wr_commit(wsel.commit), .locked(locked),
    .wdata(bus_wdata[AF_W-1:0]), .commit(commit));

  afg_altfn #(.AF_W(AF_W)) u_altfn (
    .clk(clk), .rst_n(rst_int_n), .wr_af(wsel.altfn), .mask(commit),
    .wdata(bus_wdata[AF_W-1:0]), .af(af));

  afg_rdmux #(.AW(ADDR_W), .DW(DATA_W), .AFW(AF_W)) u_rdmux (
    .addr(bus_addr), .locked(locked), .commit(commit), .af(af),
    .rdata(bus_rdata));

  assign af_sel_o = af;

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({wsel.lock, wsel.commit, wsel.altfn})); // R9
endmodule

// File: tb/afg_guard_tb.sv
`timescale 1ns/1ps
module afg_guard_tb;
  localparam logic [31:0] KEY = 32'h0ACC_E551;
  localparam logic [11:0] A_AF = 12'h420, A_LK = 12'h520, A_CM = 12'h524;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [7:0]  af_sel_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [7:0] exp_af;
  logic [7:0] exp_cm;

  always #2.5 clk = ~clk;

  afg_guard u_dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .af_sel_o(af_sel_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    rd(A_LK, v); chk("R1 lock", v, 32'd1);
    rd(A_CM, v); chk("R1 commit", v, 32'hFF);
    rd(A_AF, v); chk("R1 altfn", v, 32'h0);
    chk("R1 port", {24'h0, af_sel_o}, 32'h0);

    wr(A_CM, 32'h0);
    rd(A_CM, v); chk("R4 locked commit write", v, 32'hFF);

    exp_af = 8'h0; exp_cm = 8'hFF;
    wr(A_AF, 32'hA5); exp_af = 8'hA5;
    rd(A_AF, v); chk("R7 full mask", v, {24'h0, exp_af});
    chk("R8 port", {24'h0, af_sel_o}, {24'h0, exp_af});

    for (int i = 0; i < 32; i++) begin
      wr(A_LK, KEY);
      rd(A_LK, v); chk("R2 key opens", v, 32'd0);
      wr(A_LK, KEY ^ (32'd1 << i));
      rd(A_LK, v); chk("R3 near miss closes", v, 32'd1);
    end
    wr(A_CM, 32'h12);
    rd(A_CM, v); chk("R4 commit after close", v, 32'hFF);

    wr(A_LK, KEY);
    wr(A_CM, 32'hFFFF_FF3C); exp_cm = 8'h3C;
    rd(A_CM, v); chk("R5 truncation", v, 32'h3C);

    for (int c = 0; c < 256; c++) begin
      wr(A_CM, {24'hABCDEF, c[7:0]}); exp_cm = c[7:0];
      rd(A_CM, v); chk("R5 commit store", v, {24'h0, exp_cm});
      for (int p = 0; p < 16; p++) begin
        logic [7:0] w;
        w = 8'((p * 29) ^ 8'h5A ^ c);
        wr(A_AF, {24'hFFFFFF, w});
        exp_af = (exp_af & ~exp_cm) | (w & exp_cm);
        rd(A_AF, v); chk("R7 masked write", v, {24'h0, exp_af});
        chk("R8 port", {24'h0, af_sel_o}, {24'h0, exp_af});
      end
      rd(A_LK, v); chk("R6 stays open", v, 32'd0);
    end

    wr(A_CM, 32'h0F); exp_cm = 8'h0F;
    wr(12'h000, 32'hFFFF_FFFF);
    wr(12'h41C, 32'hFFFF_FFFF);
    wr(12'h528, 32'h0);
    wr(12'hFFC, KEY);
    rd(A_CM, v); chk("R9 commit untouched", v, {24'h0, exp_cm});
    rd(A_AF, v); chk("R9 altfn untouched", v, {24'h0, exp_af});
    rd(A_LK, v); chk("R9 lock untouched", v, 32'd0);
    rd(12'h000, v); chk("R9 unmapped read", v, 32'h0);
    rd(12'h41C, v); chk("R9 unmapped read", v, 32'h0);
    rd(12'h528, v); chk("R9 unmapped read", v, 32'h0);

    wr(A_LK, 32'h0);
    rd(A_LK, v); chk("R3 zero closes", v, 32'd1);
    wr(A_CM, 32'hF0);
    rd(A_CM, v); chk("R4 final frozen", v, {24'h0, exp_cm});
    wr(A_AF, 32'h00);
    exp_af = exp_af & ~exp_cm;
    rd(A_AF, v); chk("R7 closed still masked", v, {24'h0, exp_af});
    chk("R8 port", {24'h0, af_sel_o}, {24'h0, exp_af});

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule